// File: doc/BRIEF.md
# Per-Lane Delay Code Stepper

This block keeps a delay setting for each byte lane of a memory interface. A setting has four fields: a coarse bit, a clock-delay count, a tap count and an interpolator phase. A training engine moves one setting at a time by one unit, up or down. Each field carries into or borrows from the next one, and the tap field's ceiling depends on the memory clock grade. With every accepted step or load, the block also works out two bypass control bits for the lane. It does this by placing the new tap and phase against two threshold points, and each clock grade has its own pair of points.

All pins are plain control and status. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure. A strobe held high for one cycle requests one step. The result shows on the outputs after the next rising clock edge. A rejected step does not change the setting, and the lane's error flag is high for one cycle. Lanes share the clock grade and are otherwise independent.

Top module: `dly_code_stepper`

## Requirements
- R1: After reset every lane reads coarse 0, clock delay 0, tap 0, phase 0, bypass enable 1, bypass select 1 and error 0.
- R2: An increment raises the phase by one while it is below 6. From phase 6 it clears the phase and raises the tap by one, provided the tap is below the grade's maximum.
- R3: The grade input selects the maximum tap: code 0 gives 12, code 1 gives 10, code 2 gives 13, and code 3 behaves like code 0.
- R4: An increment with phase 6 and the tap at its maximum clears phase and tap and raises clock delay by one, provided clock delay is below 2.
- R5: An increment with phase 6, the tap at its maximum, clock delay 2 and coarse 0 clears phase and tap, lowers clock delay by one and sets coarse to 1.
- R6: An increment at phase 6, maximum tap, clock delay 2 and coarse 1 is rejected. The setting and bypass bits stay unchanged, and the error flag is 1 for exactly the following cycle.
- R7: A decrement lowers the phase by one while it is above 0. A phase borrow reloads phase 6 and lowers the tap. A tap borrow reloads phase 6 and the grade's maximum tap and lowers clock delay.
- R8: A decrement with phase, tap and clock delay all 0 and coarse 1 reloads phase 6 and the maximum tap, sets clock delay to 1 and clears coarse.
- R9: A decrement of the all-zero setting is rejected. The setting stays zero, and the error flag is 1 for the following cycle.
- R10: The bypass bits depend on the new (tap, phase) pair, compared lexicographically with the grade's low point L and high point H. L/H are (3,2)/(10,3) for code 0 and 3, (2,6)/(8,7) for code 1, and (3,6)/(11,4) for code 2. Below L, enable is 1 and select is 1. From L up to below H, both bits are 0. From H on, enable is 1 and select is 0.
- R11: A change of grade alone does not alter the registered bypass bits. They are recomputed only on an accepted step or a load.
- R12: A load writes all four fields of that lane from the load code, with coarse in bit 9, clock delay in bits 8:7, tap in bits 6:3 and phase in bits 2:0. A load has priority over both strobes.
- R13: When increment and decrement are both high in the same cycle, only the increment is performed.
- R14: Strobes and loads for one lane do not change any other lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| grade | input | 2 | Memory clock grade code |
| inc | input | LANES | Per-lane increment strobe |
| dec | input | LANES | Per-lane decrement strobe |
| load | input | LANES | Per-lane load strobe |
| load_code | input | LANES x 10 | Per-lane value to load {coarse, clock delay, tap, phase} |
| coarse | output | LANES x 1 | Coarse field |
| clk_dly | output | LANES x 2 | Clock-delay field |
| tap | output | LANES x 4 | Tap field |
| phase | output | LANES x 3 | Interpolator phase field |
| byp_en | output | LANES | Bypass enable bit |
| byp_sel | output | LANES | Bypass select bit |
| err | output | LANES | One-cycle pulse after a rejected step |

## Verification
The bench builds the block with LANES set to 2. That is the smallest count at which one lane can be stepped or loaded while the other one is watched for unwanted changes, and where two lanes can take opposite strobes in the same cycle. The field widths stay at their defaults, so all four grade codes, both carry limits of the clock-delay field and the full coarse range can be reached through loads of edge settings rather than long step sequences. Every threshold point is approached from both sides, and a grade change is made while the bypass bits are held.

// File: rtl/dstep_pkg.sv
package dstep_pkg;
  localparam int COARSE_W = 1;
  localparam int CLK_W    = 2;
  localparam int TAP_W    = 4;
  localparam int PI_W     = 3;
  localparam int CODE_W   = COARSE_W + CLK_W + TAP_W + PI_W;

  localparam int PI_TOP     = 6;
  localparam int CLK_TOP    = 2;
  localparam int COARSE_TOP = 1;

  typedef struct packed {
    logic [COARSE_W-1:0] coarse;
    logic [CLK_W-1:0]    clk;
    logic [TAP_W-1:0]    tap;
    logic [PI_W-1:0]     pi;
  } dly_code_t;

  typedef enum logic [1:0] {
    GRADE_800  = 2'd0,
    GRADE_1066 = 2'd1,
    GRADE_1333 = 2'd2,
    GRADE_RSV  = 2'd3
  } grade_e;

  typedef struct packed {
    logic [TAP_W-1:0] max_tap;
    logic [TAP_W-1:0] lo_tap;
    logic [PI_W-1:0]  lo_pi;
    logic [TAP_W-1:0] hi_tap;
    logic [PI_W-1:0]  hi_pi;
  } grade_lim_t;
endpackage

// File: rtl/dstep_grade_limits.sv
module dstep_grade_limits
  import dstep_pkg::*;
(
  input  logic [1:0] grade,
  output grade_lim_t lim
);
  always_comb begin
    case (grade_e'(grade))
      GRADE_1066: begin
        lim.max_tap = TAP_W'(10);
        lim.lo_tap  = TAP_W'(2);
        lim.lo_pi   = PI_W'(6);
        lim.hi_tap  = TAP_W'(8);
        lim.hi_pi   = PI_W'(7);
      end
      GRADE_1333: begin
        lim.max_tap = TAP_W'(13);
        lim.lo_tap  = TAP_W'(3);
        lim.lo_pi   = PI_W'(6);
        lim.hi_tap  = TAP_W'(11);
        lim.hi_pi   = PI_W'(4);
      end
      default: begin
        lim.max_tap = TAP_W'(12);
        lim.lo_tap  = TAP_W'(3);
        lim.lo_pi   = PI_W'(2);
        lim.hi_tap  = TAP_W'(10);
        lim.hi_pi   = PI_W'(3);
      end
    endcase
  end
endmodule

// File: rtl/dstep_next.sv
module dstep_next
  import dstep_pkg::*;
(
  input  dly_code_t        code_i,
  input  logic [TAP_W-1:0] max_tap,
  input  logic             up,
  output dly_code_t        code_o,
  output logic             ok
);
  localparam logic [PI_W-1:0]     PI_TOP_V     = PI_W'(PI_TOP);
  localparam logic [CLK_W-1:0]    CLK_TOP_V    = CLK_W'(CLK_TOP);
  localparam logic [COARSE_W-1:0] COARSE_TOP_V = COARSE_W'(COARSE_TOP);

  always_comb begin
    code_o = code_i;
    ok     = 1'b1;
    if (up) begin
      if (code_i.pi < PI_TOP_V) begin
        code_o.pi = code_i.pi + PI_W'(1);
      end else if (code_i.tap < max_tap) begin
        code_o.pi  = '0;
        code_o.tap = code_i.tap + TAP_W'(1);
      end else if (code_i.clk < CLK_TOP_V) begin
        code_o.pi  = '0;
        code_o.tap = '0;
        code_o.clk = code_i.clk + CLK_W'(1);
      end else if (code_i.coarse < COARSE_TOP_V) begin
        code_o.pi     = '0;
        code_o.tap    = '0;
        code_o.clk    = code_i.clk - CLK_W'(1);
        code_o.coarse = code_i.coarse + COARSE_W'(1);
      end else begin
        ok = 1'b0;
      end
    end else begin
      if (code_i.pi != '0) begin
        code_o.pi = code_i.pi - PI_W'(1);
      end else if (code_i.tap != '0) begin
        code_o.pi  = PI_TOP_V;
        code_o.tap = code_i.tap - TAP_W'(1);
      end else if (code_i.clk != '0) begin
        code_o.pi  = PI_TOP_V;
        code_o.tap = max_tap;
        code_o.clk = code_i.clk - CLK_W'(1);
      end else if (code_i.coarse != '0) begin
        code_o.pi     = PI_TOP_V;
        code_o.tap    = max_tap;
        code_o.clk    = code_i.clk + CLK_W'(1);
        code_o.coarse = code_i.coarse - COARSE_W'(1);
      end else begin
        ok = 1'b0;
      end
    end
  end
endmodule

// File: rtl/dstep_bypass.sv
module dstep_bypass
  import dstep_pkg::*;
(
  input  logic [TAP_W-1:0] tap,
  input  logic [PI_W-1:0]  pi,
  input  grade_lim_t       lim,
  output logic             en,
  output logic             sel
);
  logic below_lo, below_hi;

  assign below_lo = (tap < lim.lo_tap) || ((tap == lim.lo_tap) && (pi < lim.lo_pi));
  assign below_hi = (tap < lim.hi_tap) || ((tap == lim.hi_tap) && (pi < lim.hi_pi));

  always_comb begin
    if (below_lo) begin
      en  = 1'b1;
      sel = 1'b1;
    end else if (below_hi) begin
      en  = 1'b0;
      sel = 1'b0;
    end else begin
      en  = 1'b1;
      sel = 1'b0;
    end
  end
endmodule

// File: rtl/dstep_lane.sv
module dstep_lane
  import dstep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  grade_lim_t lim,
  input  logic       inc,
  input  logic       dec,
  input  logic       load,
  input  dly_code_t  load_code,
  output dly_code_t  code_q,
  output logic       byp_en_q,
  output logic       byp_sel_q,
  output logic       err_q
);
  dly_code_t step_code, cand;
  logic      step_ok, cand_en, cand_sel;

  dstep_next u_next (
    .code_i  (code_q),
    .max_tap (lim.max_tap),
    .up      (inc),
    .code_o  (step_code),
    .ok      (step_ok)
  );

  assign cand = load ? load_code : step_code;

  dstep_bypass u_byp (
    .tap (cand.tap),
    .pi  (cand.pi),
    .lim (lim),
    .en  (cand_en),
    .sel (cand_sel)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q    <= '0;
      byp_en_q  <= 1'b1;
      byp_sel_q <= 1'b1;
      err_q     <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (load || ((inc || dec) && step_ok)) begin
        code_q    <= cand;
        byp_en_q  <= cand_en;
        byp_sel_q <= cand_sel;
      end else if (inc || dec) begin
        err_q <= 1'b1;
      end
    end
  end

  // R6
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (code_q == $past(code_q)) && (byp_en_q == $past(byp_en_q)));

  // R12
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (code_q == $past(load_code)));

  // R11
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !dec && !load) |=> ($stable(code_q) && $stable(byp_en_q) && $stable(byp_sel_q) && !err_q));

  // R2
  step_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((inc || dec) && !load) |=> (err_q || (code_q != $past(code_q))));

  // R10
  byp_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!byp_en_q && byp_sel_q));
endmodule

// File: rtl/dly_code_stepper.sv
module dly_code_stepper
  import dstep_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [1:0]                    grade,
  input  logic [LANES-1:0]              inc,
  input  logic [LANES-1:0]              dec,
  input  logic [LANES-1:0]              load,
  input  logic [LANES-1:0][CODE_W-1:0]  load_code,
  output logic [LANES-1:0][COARSE_W-1:0] coarse,
  output logic [LANES-1:0][CLK_W-1:0]   clk_dly,
  output logic [LANES-1:0][TAP_W-1:0]   tap,
  output logic [LANES-1:0][PI_W-1:0]    phase,
  output logic [LANES-1:0]              byp_en,
  output logic [LANES-1:0]              byp_sel,
  output logic [LANES-1:0]              err
);
  grade_lim_t lim;

  dstep_grade_limits u_lim (
    .grade (grade),
    .lim   (lim)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    dly_code_t code_q;

    dstep_lane u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .lim       (lim),
      .inc       (inc[l]),
      .dec       (dec[l]),
      .load      (load[l]),
      .load_code (dly_code_t'(load_code[l])),
      .code_q    (code_q),
      .byp_en_q  (byp_en[l]),
      .byp_sel_q (byp_sel[l]),
      .err_q     (err[l])
    );

    assign coarse[l]  = code_q.coarse;
    assign clk_dly[l] = code_q.clk;
    assign tap[l]     = code_q.tap;
    assign phase[l]   = code_q.pi;
  end
endmodule

// File: tb/dly_code_stepper_bench.sv
module dly_code_stepper_bench;
  localparam int L = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] grade = 2'd0;
  logic [L-1:0] inc = '0, dec = '0, load = '0;
  logic [L-1:0][9:0] load_code = '0;
  logic [L-1:0][0:0] coarse;
  logic [L-1:0][1:0] clk_dly;
  logic [L-1:0][3:0] tap;
  logic [L-1:0][2:0] phase;
  logic [L-1:0] byp_en, byp_sel, err;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dly_code_stepper #(.LANES(L)) u_dly_code_stepper (
    .clk(clk), .rst_n(rst_n), .grade(grade), .inc(inc), .dec(dec),
    .load(load), .load_code(load_code), .coarse(coarse), .clk_dly(clk_dly),
    .tap(tap), .phase(phase), .byp_en(byp_en), .byp_sel(byp_sel), .err(err)
  );

  function automatic logic [9:0] mk(int c, int k, int t, int p);
    return {c[0], k[1:0], t[3:0], p[2:0]};
  endfunction

  task automatic chk(string req, int ln, logic [9:0] ecode, logic een, logic esel, logic eerr);
    logic [12:0] act, exp;
    act = {coarse[ln], clk_dly[ln], tap[ln], phase[ln], byp_en[ln], byp_sel[ln], err[ln]};
    exp = {ecode, een, esel, eerr};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s lane%0d actual c%0d k%0d t%0d p%0d en%0d sel%0d err%0d expected c%0d k%0d t%0d p%0d en%0d sel%0d err%0d",
        req, ln, act[12], act[11:10], act[9:6], act[5:3], act[2], act[1], act[0],
        exp[12], exp[11:10], exp[9:6], exp[5:3], exp[2], exp[1], exp[0]);
    end
  endtask

  // one cycle of stimulus, outputs checked at the following falling edge
  task automatic cyc(logic [L-1:0] i, logic [L-1:0] d, logic [L-1:0] ld,
                     logic [9:0] c0, logic [9:0] c1);
    @(negedge clk);
    inc = i; dec = d; load = ld; load_code[0] = c0; load_code[1] = c1;
    @(negedge clk);
    inc = '0; dec = '0; load = '0;
  endtask

  task automatic ld0(logic [9:0] c);
    cyc(2'b00, 2'b00, 2'b01, c, '0);
  endtask

  task automatic t_reset;
    chk("R1", 0, mk(0,0,0,0), 1, 1, 0);
    chk("R1", 1, mk(0,0,0,0), 1, 1, 0);
  endtask

  task automatic t_phase;
    grade = 2'd0;
    cyc(2'b01, 0, 0, '0, '0);
    chk("R2", 0, mk(0,0,0,1), 1, 1, 0);
    ld0(mk(0,0,0,6));
    cyc(2'b01, 0, 0, '0, '0);
    chk("R2", 0, mk(0,0,1,0), 1, 1, 0);
  endtask

  task automatic t_tap_limit;
    for (int g = 0; g < 4; g++) begin
      int mt;
      mt = (g == 1) ? 10 : (g == 2) ? 13 : 12;
      grade = 2'(g);
      ld0(mk(0,0,mt-1,6));
      cyc(2'b01, 0, 0, '0, '0);
      chk("R3", 0, mk(0,0,mt,0), 1, 0, 0);
      ld0(mk(0,0,mt,6));
      cyc(2'b01, 0, 0, '0, '0);
      chk("R4", 0, mk(0,1,0,0), 1, 1, 0);
    end
  endtask

  task automatic t_coarse_carry;
    grade = 2'd1;
    ld0(mk(0,2,10,6));
    cyc(2'b01, 0, 0, '0, '0);
    chk("R5", 0, mk(1,1,0,0), 1, 1, 0);
  endtask

  task automatic t_overflow;
    grade = 2'd1;
    ld0(mk(1,2,10,6));
    chk("R6", 0, mk(1,2,10,6), 1, 0, 0);
    cyc(2'b01, 0, 0, '0, '0);
    chk("R6", 0, mk(1,2,10,6), 1, 0, 1);
    @(negedge clk);
    chk("R6", 0, mk(1,2,10,6), 1, 0, 0);
  endtask

  task automatic t_decrement;
    grade = 2'd2;
    ld0(mk(0,0,3,0));
    cyc(0, 2'b01, 0, '0, '0);
    chk("R7", 0, mk(0,0,2,6), 1, 1, 0);
    cyc(0, 2'b01, 0, '0, '0);
    chk("R7", 0, mk(0,0,2,5), 1, 1, 0);
    ld0(mk(0,1,0,0));
    cyc(0, 2'b01, 0, '0, '0);
    chk("R7", 0, mk(0,0,13,6), 1, 0, 0);
    ld0(mk(1,0,0,0));
    cyc(0, 2'b01, 0, '0, '0);
    chk("R8", 0, mk(0,1,13,6), 1, 0, 0);
  endtask

  task automatic t_dec_zero;
    ld0(mk(0,0,0,0));
    cyc(0, 2'b01, 0, '0, '0);
    chk("R9", 0, mk(0,0,0,0), 1, 1, 1);
  endtask

  task automatic t_bypass;
    grade = 2'd0;
    ld0(mk(0,0,3,1));
    chk("R10", 0, mk(0,0,3,1), 1, 1, 0);
    cyc(2'b01, 0, 0, '0, '0);
    chk("R10", 0, mk(0,0,3,2), 0, 0, 0);
    ld0(mk(0,0,10,2));
    chk("R10", 0, mk(0,0,10,2), 0, 0, 0);
    cyc(2'b01, 0, 0, '0, '0);
    chk("R10", 0, mk(0,0,10,3), 1, 0, 0);
    grade = 2'd2;
    ld0(mk(0,0,11,3));
    chk("R10", 0, mk(0,0,11,3), 0, 0, 0);
    cyc(2'b01, 0, 0, '0, '0);
    chk("R10", 0, mk(0,0,11,4), 1, 0, 0);
    grade = 2'd1;
    ld0(mk(0,0,2,5));
    chk("R10", 0, mk(0,0,2,5), 1, 1, 0);
    cyc(2'b01, 0, 0, '0, '0);
    chk("R10", 0, mk(0,0,2,6), 0, 0, 0);
    ld0(mk(0,0,8,6));
    chk("R10", 0, mk(0,0,8,6), 0, 0, 0);
    cyc(2'b01, 0, 0, '0, '0);
    chk("R10", 0, mk(0,0,9,0), 1, 0, 0);
  endtask

  task automatic t_grade_hold;
    grade = 2'd0;
    ld0(mk(0,0,3,0));
    chk("R11", 0, mk(0,0,3,0), 1, 1, 0);
    grade = 2'd1;
    repeat (2) @(negedge clk);
    chk("R11", 0, mk(0,0,3,0), 1, 1, 0);
    cyc(2'b01, 0, 0, '0, '0);
    chk("R11", 0, mk(0,0,3,1), 0, 0, 0);
  endtask

  task automatic t_load_prio;
    grade = 2'd1;
    cyc(2'b01, 2'b01, 2'b01, mk(0,1,5,2), '0);
    chk("R12", 0, mk(0,1,5,2), 0, 0, 0);
  endtask

  task automatic t_both;
    ld0(mk(0,0,0,3));
    cyc(2'b01, 2'b01, 0, '0, '0);
    chk("R13", 0, mk(0,0,0,4), 1, 1, 0);
  endtask

  task automatic t_lanes;
    grade = 2'd1;
    cyc(0, 0, 2'b11, mk(0,0,0,2), mk(0,0,0,2));
    cyc(2'b10, 0, 0, '0, '0);
    chk("R14", 0, mk(0,0,0,2), 1, 1, 0);
    chk("R14", 1, mk(0,0,0,3), 1, 1, 0);
    cyc(2'b10, 2'b01, 0, '0, '0);
    chk("R14", 0, mk(0,0,0,1), 1, 1, 0);
    chk("R14", 1, mk(0,0,0,4), 1, 1, 0);
    cyc(0, 0, 2'b10, '0, mk(1,2,9,1));
    chk("R14", 0, mk(0,0,0,1), 1, 1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_phase();
    t_tap_limit();
    t_coarse_carry();
    t_overflow();
    t_decrement();
    t_dec_zero();
    t_bypass();
    t_grade_hold();
    t_load_prio();
    t_both();
    t_lanes();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired, actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule